// File: doc/BRIEF.md
# Watch-Crystal Time-Base Divider

This block turns a 32.768 kHz watch-crystal clock into the slow timing signals of a handheld controller. A free-running low stage divides by 512 to make a one-cycle 64 Hz frame tick, and one of its bits is brought out as a 512 Hz square wave that drives an external voltage doubler. A second, gated stage counts frame ticks and raises a half-second interrupt request. Software can start and stop this stage, and stopping it clears its count.

Each frame tick can also raise a non-maskable interrupt request. This request has its own enable bit, and the frame tick keeps running while that bit is off. Both requests are sticky flags that stay set until the CPU acknowledges them. When the crystal-running indication drops, every count holds its value and the 512 Hz output is held low. The block has no data stream, so every pin is a plain level or one-cycle strobe with no handshake.

Top module: `lft_timebase`

## Requirements
- R1: After reset, `irq_half`, `nmi_req`, `frame_tick` and `clk_512` are all low and both enable bits are clear.
- R2: While `xtal_run` is high, `clk_512` is a square wave that is high for 32 and low for 32 crystal cycles.
- R3: While `xtal_run` is high, `frame_tick` is a one-cycle pulse every 512 crystal cycles.
- R4: While `xtal_run` is low, `clk_512` and `frame_tick` are low and no counter advances. When `xtal_run` returns, counting resumes from the held value.
- R5: A cycle with `cfg_wr_en` high loads `cfg_wr_data` into the enables, and the new value applies from the next cycle. Bit 0 enables the half-second stage and bit 1 enables the NMI.
- R6: With the half-second stage enabled, `irq_half` is set by the edge that ends the 32nd frame tick counted after the enable took effect.
- R7: Clearing the half-second enable clears the stage's count. After re-enabling, the next interrupt again needs 32 frame ticks.
- R8: When the NMI is enabled, `nmi_req` is set by the edge that ends a frame tick. When the NMI is disabled, frame ticks continue but `nmi_req` is not set.
- R9: A set request stays high until its acknowledge (`ack_half` or `ack_nmi`) is high for one cycle, and it is low from the next cycle.
- R10: If a set and an acknowledge of the same request fall in the same cycle, the request stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_xtal | input | 1 | 32.768 kHz crystal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xtal_run | input | 1 | High while the crystal oscillates |
| cfg_wr_en | input | 1 | Load strobe for the enable bits |
| cfg_wr_data | input | 2 | Bit 0 half-second enable, bit 1 NMI enable |
| ack_half | input | 1 | Acknowledge of the half-second request |
| ack_nmi | input | 1 | Acknowledge of the NMI request |
| irq_half | output | 1 | Sticky half-second interrupt request |
| nmi_req | output | 1 | Sticky 64 Hz non-maskable request |
| frame_tick | output | 1 | One-cycle 64 Hz strobe |
| clk_512 | output | 1 | 512 Hz square wave for the voltage doubler |

## Verification
The assertions check the local rules on every cycle:
- the frame tick is only one cycle wide;
- both outputs are silent while the crystal is stopped;
- a request is raised only right after a frame tick;
- a request holds until it is acknowledged, and an acknowledge clears it;
- a set wins over an acknowledge in the same cycle.

The long-range counts can only be shown by the bench scenarios. These cover the 32/32 duty of the 512 Hz wave, the 512-cycle frame period, the exact 32-tick first period after the enable, the full restart after a stop, and resuming from the frozen count after a crystal stop.

// File: rtl/lft_pkg.sv
package lft_pkg;
  // Enable register layout: bit 0 half-second stage, bit 1 NMI.
  typedef struct packed {
    logic nmi_en;
    logic half_en;
  } lft_cfg_t;

  localparam int unsigned LFT_CFG_W = $bits(lft_cfg_t);
  localparam int unsigned LFT_NUM_REQ = 2;
  localparam int unsigned LFT_REQ_HALF = 0;
  localparam int unsigned LFT_REQ_NMI = 1;
endpackage

// File: rtl/lft_prescaler.sv
// Free-running low stage: frame strobe on wrap, square wave from one bit.
module lft_prescaler #(
  parameter int unsigned LO_W   = 9,
  parameter int unsigned TAP_SQ = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic sq_out,
  output logic tick
);
  localparam int unsigned TAP = (TAP_SQ < LO_W) ? TAP_SQ : LO_W - 1;

  logic [LO_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (run) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign tick   = run & (&cnt_q);
  assign sq_out = run & cnt_q[TAP];
endmodule

// File: rtl/lft_half_div.sv
// Gated high stage: counts frame strobes, cleared while disabled.
module lft_half_div #(
  parameter int unsigned HI_W = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic tick,
  output logic strobe
);
  logic [HI_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!en) begin
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign strobe = en & tick & (&cnt_q);
endmodule

// File: rtl/lft_sticky.sv
// Request flag: set dominates acknowledge.
module lft_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic ack,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag <= 1'b0;
    end else if (set) begin
      flag <= 1'b1;
    end else if (ack) begin
      flag <= 1'b0;
    end
  end
endmodule

// File: rtl/lft_timebase.sv
module lft_timebase
  import lft_pkg::*;
#(
  parameter int unsigned LO_W   = 9,
  parameter int unsigned HI_W   = 5,
  parameter int unsigned TAP_SQ = 5
) (
  input  logic                 clk_xtal,
  input  logic                 rst_n,
  input  logic                 xtal_run,
  input  logic                 cfg_wr_en,
  input  logic [LFT_CFG_W-1:0] cfg_wr_data,
  input  logic                 ack_half,
  input  logic                 ack_nmi,
  output logic                 irq_half,
  output logic                 nmi_req,
  output logic                 frame_tick,
  output logic                 clk_512
);
  lft_cfg_t cfg_q;
  logic     tick_w;
  logic     half_w;
  logic [LFT_NUM_REQ-1:0] set_v;
  logic [LFT_NUM_REQ-1:0] ack_v;
  logic [LFT_NUM_REQ-1:0] flag_v;

  always_ff @(posedge clk_xtal or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (cfg_wr_en) begin
      cfg_q <= lft_cfg_t'(cfg_wr_data);
    end
  end

  lft_prescaler #(.LO_W(LO_W), .TAP_SQ(TAP_SQ)) u_pre (
    .clk    (clk_xtal),
    .rst_n  (rst_n),
    .run    (xtal_run),
    .sq_out (clk_512),
    .tick   (tick_w)
  );

  lft_half_div #(.HI_W(HI_W)) u_half (
    .clk    (clk_xtal),
    .rst_n  (rst_n),
    .en     (cfg_q.half_en),
    .tick   (tick_w),
    .strobe (half_w)
  );

  assign set_v[LFT_REQ_HALF] = half_w;
  assign set_v[LFT_REQ_NMI]  = tick_w & cfg_q.nmi_en;
  assign ack_v[LFT_REQ_HALF] = ack_half;
  assign ack_v[LFT_REQ_NMI]  = ack_nmi;

  for (genvar g = 0; g < LFT_NUM_REQ; g++) begin : g_req
    lft_sticky u_flag (
      .clk   (clk_xtal),
      .rst_n (rst_n),
      .set   (set_v[g]),
      .ack   (ack_v[g]),
      .flag  (flag_v[g])
    );
  end

  assign irq_half   = flag_v[LFT_REQ_HALF];
  assign nmi_req    = flag_v[LFT_REQ_NMI];
  assign frame_tick = tick_w;
endmodule

// File: rtl/lft_timebase_chk.sv
module lft_timebase_chk (
  input logic clk_xtal,
  input logic rst_n,
  input logic xtal_run,
  input logic nmi_en,
  input logic ack_half,
  input logic ack_nmi,
  input logic irq_half,
  input logic nmi_req,
  input logic frame_tick,
  input logic clk_512
);
  assert_tick_narrow_R3: assert property (@(posedge clk_xtal) disable iff (!rst_n)
    frame_tick |=> !frame_tick);

  assert_stop_quiet_R4: assert property (@(posedge clk_xtal) disable iff (!rst_n)
    !xtal_run |-> (!clk_512 && !frame_tick));

  assert_half_src_R6: assert property (@(posedge clk_xtal) disable iff (!rst_n)
    $rose(irq_half) |-> $past(frame_tick));

  assert_nmi_src_R8: assert property (@(posedge clk_xtal) disable iff (!rst_n)
    $rose(nmi_req) |-> $past(frame_tick && nmi_en));

  assert_nmi_hold_R9: assert property (@(posedge clk_xtal) disable iff (!rst_n)
    (nmi_req && !ack_nmi) |=> nmi_req);

  assert_half_hold_R9: assert property (@(posedge clk_xtal) disable iff (!rst_n)
    (irq_half && !ack_half) |=> irq_half);

  assert_half_ack_R9: assert property (@(posedge clk_xtal) disable iff (!rst_n)
    (ack_half && !frame_tick) |=> !irq_half);

  assert_set_wins_R10: assert property (@(posedge clk_xtal) disable iff (!rst_n)
    (frame_tick && nmi_en && ack_nmi) |=> nmi_req);
endmodule

bind lft_timebase lft_timebase_chk u_chk (
  .clk_xtal   (clk_xtal),
  .rst_n      (rst_n),
  .xtal_run   (xtal_run),
  .nmi_en     (cfg_q.nmi_en),
  .ack_half   (ack_half),
  .ack_nmi    (ack_nmi),
  .irq_half   (irq_half),
  .nmi_req    (nmi_req),
  .frame_tick (frame_tick),
  .clk_512    (clk_512)
);

// File: tb/test_lft_timebase.sv
module test_lft_timebase;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       xtal_run = 1'b1;
  logic       cfg_wr_en = 1'b0;
  logic [1:0] cfg_wr_data = 2'b00;
  logic       ack_half = 1'b0;
  logic       ack_nmi = 1'b0;
  logic       irq_half, nmi_req, frame_tick, clk_512;
  int         n_chk = 0;
  int         n_bad = 0;

  always #2.5 clk = ~clk;

  lft_timebase i_lft_timebase (
    .clk_xtal    (clk),
    .rst_n       (rst_n),
    .xtal_run    (xtal_run),
    .cfg_wr_en   (cfg_wr_en),
    .cfg_wr_data (cfg_wr_data),
    .ack_half    (ack_half),
    .ack_nmi     (ack_nmi),
    .irq_half    (irq_half),
    .nmi_req     (nmi_req),
    .frame_tick  (frame_tick),
    .clk_512     (clk_512)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [1:0] v);
    cfg_wr_en = 1'b1;
    cfg_wr_data = v;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  // Ends at the negedge after the edge that closed a frame tick.
  task automatic wait_tick();
    while (!frame_tick) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 irq_half", irq_half, 0);
    check("R1 nmi_req", nmi_req, 0);
    check("R1 frame_tick", frame_tick, 0);
    check("R1 clk_512", clk_512, 0);
  endtask

  task automatic t_square();
    int n;
    while (clk_512) @(negedge clk);
    while (!clk_512) @(negedge clk);
    n = 0;
    while (clk_512) begin n++; @(negedge clk); end
    check("R2 high cycles", n, 32);
    n = 0;
    while (!clk_512) begin n++; @(negedge clk); end
    check("R2 low cycles", n, 32);
  endtask

  task automatic t_frame();
    int n;
    while (!frame_tick) @(negedge clk);
    n = 0;
    do begin @(negedge clk); n++; end while (!frame_tick);
    check("R3 frame period", n, 512);
    @(negedge clk);
    check("R3 tick width", frame_tick, 0);
  endtask

  task automatic t_nmi();
    wait_tick();
    check("R8 nmi off after tick", nmi_req, 0);
    wait_tick();
    check("R8 nmi off after 2nd tick", nmi_req, 0);
    write_cfg(2'b10);
    wait_tick();
    check("R8 nmi set on tick", nmi_req, 1);
    repeat (20) @(negedge clk);
    check("R9 nmi held", nmi_req, 1);
    ack_nmi = 1'b1;
    @(negedge clk);
    ack_nmi = 1'b0;
    check("R9 nmi cleared by ack", nmi_req, 0);
    write_cfg(2'b00);
  endtask

  task automatic t_collide();
    write_cfg(2'b10);
    while (!frame_tick) @(negedge clk);
    ack_nmi = 1'b1;
    @(negedge clk);
    ack_nmi = 1'b0;
    check("R10 set beats ack", nmi_req, 1);
    ack_nmi = 1'b1;
    @(negedge clk);
    ack_nmi = 1'b0;
    check("R10 later ack clears", nmi_req, 0);
    write_cfg(2'b00);
  endtask

  task automatic t_half_first();
    write_cfg(2'b01);
    repeat (31) wait_tick();
    check("R6 no irq after 31 ticks", irq_half, 0);
    wait_tick();
    check("R6 irq after 32 ticks", irq_half, 1);
    check("R5 nmi stays off", nmi_req, 0);
    ack_half = 1'b1;
    @(negedge clk);
    ack_half = 1'b0;
    check("R9 irq_half cleared", irq_half, 0);
  endtask

  task automatic t_half_restart();
    repeat (10) wait_tick();
    write_cfg(2'b00);
    write_cfg(2'b01);
    repeat (31) wait_tick();
    check("R7 no irq 31 ticks after restart", irq_half, 0);
    wait_tick();
    check("R7 irq 32 ticks after restart", irq_half, 1);
    ack_half = 1'b1;
    @(negedge clk);
    ack_half = 1'b0;
    write_cfg(2'b00);
  endtask

  task automatic t_xtal_stop();
    int n;
    int seen;
    while (!frame_tick) @(negedge clk);
    xtal_run = 1'b0;
    #1;
    check("R4 tick low when stopped", frame_tick, 0);
    check("R4 clk_512 low when stopped", clk_512, 0);
    seen = 0;
    repeat (1000) begin
      @(negedge clk);
      if (frame_tick || clk_512) seen++;
    end
    check("R4 silent while stopped", seen, 0);
    xtal_run = 1'b1;
    #1;
    check("R4 resumes from held count", frame_tick, 1);
    n = 0;
    do begin @(negedge clk); n++; end while (!frame_tick);
    check("R4 period after resume", n, 512);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_square();
    t_frame();
    t_nmi();
    t_collide();
    t_half_first();
    t_half_restart();
    t_xtal_stop();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule